// File: doc/BRIEF.md
# I2C Master Byte Transfer Controller

This block drives an I2C bus as a master, one word at a time, under the control of software-style register writes. Software loads a shift register with a 7-bit slave address and a direction bit, then issues one control write that sets the master, transmit, busy and release flags together. The block then produces a START condition, clocks the word out MSB first, and gives the slave a ninth clock in which to acknowledge. On the falling edge that ends the word, the block raises a one-cycle interrupt, clears its release flag and stretches SCL low. It holds SCL low until software either releases the next word or asks for a STOP.

The acknowledge level seen in the ninth clock is kept as a status bit. After an address word that the slave acknowledged, the transmit flag takes the value the direction bit implies. Later words in the same transfer therefore go the right way without software changing the mode. The SCL half-period is `clk_div + 1` system clocks. The word length and the acknowledge clock can be set on each control write. A data-register write that arrives while the bus is being clocked is dropped and flagged, so the word in flight stays intact. The bus pins are open-drain style: the block only ever pulls a line low.

Control word layout (`ctl_wdata`): bit 7 master, bit 6 transmit, bit 5 busy, bit 4 release, bit 3 acknowledge-clock enable, bits 2:0 word length.

Top module: `i2c_byte_master`

## Requirements
- R1: A START begins only when a control write in the idle phase, with `st_busy` low, has bits 7, 6, 5 and 4 all set. Any other control write in the idle phase leaves the bus released and `st_busy`/`st_master` low. A started transfer sets `st_master`, `st_tx` and `st_busy`.
- R2: START pulls SDA low while SCL stays released for `clk_div+1` cycles before SCL first goes low. Every later SCL low phase and high phase also lasts `clk_div+1` cycles.
- R3: Data bits leave MSB first from the shift register, and SDA changes only while SCL is low. A length field of 0 means 8 bits; a value n from 1 to 7 means n bits. With bit 3 set, one more clock follows the data. In that clock the master releases SDA when transmitting and pulls it low when receiving.
- R4: In the cycle after the falling SCL edge that ends the last clock of a word, `irq` is high for exactly one cycle and `st_pend` drops to 0.
- R5: While `st_pend` is 0, SCL is held low.
- R6: After the first word of a transfer, `st_tx` becomes the inverse of that word's bit 0 (1 = read) only if the acknowledge clock sampled SDA low. On a NACK, or with no acknowledge clock, `st_tx` is unchanged.
- R7: After reset the bus lines are released, `st_master`, `st_tx`, `st_busy`, `st_wcol` and `irq` are 0, and `st_pend` is 1.
- R8: `st_lrb` holds the SDA level sampled in the last acknowledge clock; 1 means NACK.
- R9: A control write while SCL is stretched, with bit 4 set and bits 7 and 5 clear, produces a STOP. The block pulls SDA low with SCL low, then releases SCL, then releases SDA, each for `clk_div+1` cycles, and then clears `st_busy`. `st_master` clears at the write.
- R10: A data write outside the idle and stretched phases is dropped and sets `st_wcol`, and the word in flight is sent unchanged. Any control write clears `st_wcol`.
- R11: When `st_tx` is 0, SDA is sampled at the end of each data clock's high phase and shifted into `rx_data` at bit 0.
- R12: A control write while SCL is stretched, with bits 7, 5 and 4 set, starts the next word. `st_pend` returns to 1, and the transmit flag from the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | SCL half-period minus one, in system clocks |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5+log2(DW) | Control word |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | DW | Data register write value |
| rx_data | output | DW | Shift register contents |
| sda_in | input | 1 | Sampled SDA line level |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| irq | output | 1 | End-of-word interrupt pulse |
| st_master | output | 1 | Master flag |
| st_tx | output | 1 | Transmit flag |
| st_busy | output | 1 | Bus busy flag |
| st_pend | output | 1 | Release flag (0 while stretching) |
| st_lrb | output | 1 | Last acknowledge level |
| st_wcol | output | 1 | Write collision flag |

## Verification
The hardest case to reach is the automatic direction change. It needs an address word whose direction bit says read, a slave that pulls SDA low in exactly the ninth high phase, and then a further word whose SDA ownership has to follow the new mode. The bench reaches it by driving the slave from the same per-cycle expectation queue it uses to check the bus. Every queued cycle carries the level the bench expects on each line and whether the emulated slave pulls SDA. The read is followed by a NACKed read address, which must leave the mode alone, and by a short 3-bit received word with no acknowledge clock. The collision case is reached by writing the data register mid-address and then checking, cycle by cycle, that the address still goes out unchanged.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_START   = 3'd1,
    PH_LOW     = 3'd2,
    PH_HIGH    = 3'd3,
    PH_HOLD    = 3'd4,
    PH_STOP_LO = 3'd5,
    PH_STOP_HI = 3'd6,
    PH_STOP_END = 3'd7
  } phase_t;
endpackage

// File: rtl/i2cm_halfper.sv
// Half-period tick generator: one tick every div+1 cycles while running.
module i2cm_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = !hold && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (hold || tick)   cnt <= div;
    else                     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/i2cm_bitcnt.sv
// Counts SCL clocks within one word.
module i2cm_bitcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] idx,
  output logic             last
);
  assign last = (idx == total - {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (inc)  idx <= idx + 1'b1;
  end
endmodule

// File: rtl/i2cm_shreg.sv
// Data register that doubles as the bit shifter.
module i2cm_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          bit_in,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= load_val;
    else if (shift)  q <= {q[DW-2:0], bit_in};
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 8,
  localparam int BC_W  = $clog2(DW),
  localparam int CW    = 5 + BC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             ctl_we,
  input  logic [CW-1:0]    ctl_wdata,
  input  logic             dat_we,
  input  logic [DW-1:0]    dat_wdata,
  output logic [DW-1:0]    rx_data,
  input  logic             sda_in,
  output logic             scl_low,
  output logic             sda_low,
  output logic             irq,
  output logic             st_master,
  output logic             st_tx,
  output logic             st_busy,
  output logic             st_pend,
  output logic             st_lrb,
  output logic             st_wcol
);
  localparam int CNT_W = $clog2(DW + 2);

  phase_t            phase;
  logic              ack_en, dir_bit, first_word;
  logic [BC_W-1:0]   len_f;
  logic              tick, bit_last;
  logic [CNT_W-1:0]  bit_idx, n_data, n_total;
  logic [DW-1:0]     sh_q;

  // control word fields
  logic w_mst, w_trx, w_bb, w_pin, w_ack;
  logic [BC_W-1:0] w_len;
  assign w_mst = ctl_wdata[CW-1];
  assign w_trx = ctl_wdata[CW-2];
  assign w_bb  = ctl_wdata[CW-3];
  assign w_pin = ctl_wdata[CW-4];
  assign w_ack = ctl_wdata[CW-5];
  assign w_len = ctl_wdata[BC_W-1:0];

  logic parked, in_data, start_req, next_req, stop_req, dat_ok;
  assign parked    = (phase == PH_IDLE) || (phase == PH_HOLD);
  assign n_data    = (len_f == '0) ? CNT_W'(DW) : CNT_W'(len_f);
  assign n_total   = n_data + CNT_W'(ack_en);
  assign in_data   = bit_idx < n_data;
  assign start_req = ctl_we && (phase == PH_IDLE) && !st_busy &&
                     w_mst && w_trx && w_bb && w_pin;
  assign next_req  = ctl_we && (phase == PH_HOLD) && w_pin && w_mst && w_bb;
  assign stop_req  = ctl_we && (phase == PH_HOLD) && w_pin && !w_mst && !w_bb;
  assign dat_ok    = dat_we && parked;

  i2cm_halfper #(.DIV_W(DIV_W)) u_halfper (
    .clk(clk), .rst_n(rst_n), .hold(parked), .div(clk_div), .tick(tick)
  );

  i2cm_bitcnt #(.CNT_W(CNT_W)) u_bitcnt (
    .clk(clk), .rst_n(rst_n), .clr(parked),
    .inc((phase == PH_HIGH) && tick && !bit_last),
    .total(n_total), .idx(bit_idx), .last(bit_last)
  );

  i2cm_shreg #(.DW(DW)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(dat_ok), .load_val(dat_wdata),
    .shift((phase == PH_HIGH) && tick && in_data), .bit_in(sda_in), .q(sh_q)
  );

  assign rx_data = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      st_master  <= 1'b0;
      st_tx      <= 1'b0;
      st_busy    <= 1'b0;
      st_pend    <= 1'b1;
      st_lrb     <= 1'b0;
      st_wcol    <= 1'b0;
      irq        <= 1'b0;
      ack_en     <= 1'b0;
      len_f      <= '0;
      dir_bit    <= 1'b0;
      first_word <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ctl_we && parked) begin
        ack_en <= w_ack;
        len_f  <= w_len;
      end
      if (ctl_we)               st_wcol <= 1'b0;
      else if (dat_we && !parked) st_wcol <= 1'b1;

      unique case (phase)
        PH_IDLE: if (start_req) begin
          phase      <= PH_START;
          st_master  <= 1'b1;
          st_tx      <= 1'b1;
          st_busy    <= 1'b1;
          st_pend    <= 1'b1;
          dir_bit    <= sh_q[0];
          first_word <= 1'b1;
        end
        PH_START: if (tick) phase <= PH_LOW;
        PH_LOW:   if (tick) phase <= PH_HIGH;
        PH_HIGH:  if (tick) begin
          if (!in_data) st_lrb <= sda_in;
          if (bit_last) begin
            phase      <= PH_HOLD;
            st_pend    <= 1'b0;
            irq        <= 1'b1;
            first_word <= 1'b0;
            if (first_word && !in_data && !sda_in) st_tx <= ~dir_bit;
          end else begin
            phase <= PH_LOW;
          end
        end
        PH_HOLD: begin
          if (next_req) begin
            phase   <= PH_LOW;
            st_pend <= 1'b1;
          end else if (stop_req) begin
            phase     <= PH_STOP_LO;
            st_master <= 1'b0;
            st_pend   <= 1'b1;
          end
        end
        PH_STOP_LO:  if (tick) phase <= PH_STOP_HI;
        PH_STOP_HI:  if (tick) phase <= PH_STOP_END;
        PH_STOP_END: if (tick) begin
          phase   <= PH_IDLE;
          st_busy <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_low = (phase == PH_LOW) || (phase == PH_HOLD) || (phase == PH_STOP_LO);
    unique case (phase)
      PH_START, PH_STOP_LO, PH_STOP_HI: sda_low = 1'b1;
      PH_LOW, PH_HIGH: sda_low = in_data ? (st_tx && !sh_q[DW-1]) : !st_tx;
      default: sda_low = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_low,
  input logic sda_low,
  input logic irq,
  input logic st_pend,
  input logic st_busy,
  input logic st_master,
  input logic st_wcol,
  input logic dat_we
);
  // R5: stretched while release flag is clear
  assert_scl_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_pend |-> scl_low);

  // R4: interrupt coincides with stretch and lasts one cycle
  assert_irq_with_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!st_pend && scl_low));
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R2: SDA falling with SCL high only as START of an owned bus
  assert_start_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && !scl_low) |-> (st_busy && st_master));

  // R9: SDA rising with SCL high only as STOP after master cleared
  assert_stop_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_low) && !scl_low) |-> !st_master);
  assert_free_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_busy) |-> (!scl_low && !sda_low));

  // R10: collision flag only follows a data write
  assert_wcol_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_wcol) |-> $past(dat_we));
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_low(scl_low), .sda_low(sda_low),
  .irq(irq), .st_pend(st_pend), .st_busy(st_busy), .st_master(st_master),
  .st_wcol(st_wcol), .dat_we(dat_we)
);

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] clk_div;
  logic ctl_we = 1'b0, dat_we = 1'b0;
  logic [7:0] ctl_wdata = '0, dat_wdata = '0;
  logic [DW-1:0] rx_data;
  logic sda_in, scl_low, sda_low, irq;
  logic st_master, st_tx, st_busy, st_pend, st_lrb, st_wcol;

  int checks = 0, errors = 0, irq_cnt = 0, half = 4;
  logic [2:0] expq[$];          // {scl_low, sda_low, slave_pull} per cycle
  logic rest_scl = 1'b0, rest_sda = 1'b0, slave_pull = 1'b0;
  bit mon_on = 0;

  assign sda_in = !sda_low && !slave_pull;

  i2c_byte_master #(.DW(DW), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .rx_data(rx_data), .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low),
    .irq(irq), .st_master(st_master), .st_tx(st_tx), .st_busy(st_busy),
    .st_pend(st_pend), .st_lrb(st_lrb), .st_wcol(st_wcol)
  );

  always #(CLK_P/2) clk = ~clk;

  // per-cycle reference comparison of the bus (R2, R3, R5, R9)
  always @(posedge clk) begin
    logic [2:0] e;
    #1;
    if (irq) irq_cnt++;
    if (mon_on) begin
      if (expq.size() > 0) e = expq.pop_front();
      else e = {rest_scl, rest_sda, 1'b0};
      slave_pull = e[0];
      checks++;
      if (scl_low !== e[2] || sda_low !== e[1]) begin
        errors++;
        $display("FAIL R3 bus at %0t: scl_low,sda_low got %b%b expected %b%b",
                 $time, scl_low, sda_low, e[2], e[1]);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, expv);
    end
  endtask

  task automatic push_n(input logic s, input logic d, input logic p, input int n);
    for (int i = 0; i < n; i++) expq.push_back({s, d, p});
  endtask

  task automatic push_start();
    push_n(1'b0, 1'b1, 1'b0, half);
  endtask

  task automatic push_tx(input logic [7:0] b, input int n, input bit ack, input bit s_ack);
    for (int i = 0; i < n; i++) begin
      push_n(1'b1, !b[7-i], 1'b0, half);
      push_n(1'b0, !b[7-i], 1'b0, half);
    end
    if (ack) begin
      push_n(1'b1, 1'b0, s_ack, half);
      push_n(1'b0, 1'b0, s_ack, half);
    end
    rest_scl = 1'b1; rest_sda = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b, input int n, input bit ack);
    for (int i = 0; i < n; i++) begin
      push_n(1'b1, 1'b0, !b[n-1-i], half);
      push_n(1'b0, 1'b0, !b[n-1-i], half);
    end
    if (ack) begin
      push_n(1'b1, 1'b1, 1'b0, half);
      push_n(1'b0, 1'b1, 1'b0, half);
    end
    rest_scl = 1'b1; rest_sda = 1'b0;
  endtask

  task automatic push_stop();
    push_n(1'b1, 1'b1, 1'b0, half);
    push_n(1'b0, 1'b1, 1'b0, half);
    push_n(1'b0, 1'b0, 1'b0, half);
    rest_scl = 1'b0; rest_sda = 1'b0;
  endtask

  task automatic ctl_begin(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
  endtask
  task automatic ctl_end();
    @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic dat_wr(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask
  task automatic wait_drained();
    do @(negedge clk); while (expq.size() != 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clk_div = 8'd3; half = 4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    // R7 reset state
    check(!scl_low && !sda_low, "R7", "bus released", {scl_low, sda_low}, 0);
    check({st_master, st_tx, st_busy, st_wcol, irq} == 5'b0, "R7", "flags clear",
          {st_master, st_tx, st_busy, st_wcol, irq}, 0);
    check(st_pend == 1'b1, "R7", "release flag", st_pend, 1);

    // R1 write address, slave acks; R10 collision mid-word
    dat_wr(8'hA4);
    ctl_begin(8'hF8); push_start(); push_tx(8'hA4, 8, 1, 1); ctl_end();
    check(st_master && st_tx && st_busy, "R1", "flags after start",
          {st_master, st_tx, st_busy}, 7);
    repeat (15) @(negedge clk);
    dat_wr(8'hFF);
    wait_drained();
    check(irq_cnt == 1, "R4", "irq count", irq_cnt, 1);
    check(st_pend == 1'b0, "R4", "release flag cleared", st_pend, 0);
    check(st_lrb == 1'b0, "R8", "ack level", st_lrb, 0);
    check(st_tx == 1'b1, "R6", "tx after write address", st_tx, 1);
    check(st_wcol == 1'b1, "R10", "collision flag", st_wcol, 1);
    check(rx_data == 8'hA4, "R10", "word intact", rx_data, 8'hA4);
    repeat (30) @(negedge clk);
    check(scl_low == 1'b1, "R5", "scl stretched", scl_low, 1);

    // R12 next word, slave NACKs
    dat_wr(8'h3C);
    ctl_begin(8'hB8); push_tx(8'h3C, 8, 1, 0); ctl_end();
    check(st_pend == 1'b1, "R12", "release flag set", st_pend, 1);
    check(st_wcol == 1'b0, "R10", "collision cleared", st_wcol, 0);
    wait_drained();
    check(st_lrb == 1'b1, "R8", "nack level", st_lrb, 1);
    check(irq_cnt == 2, "R4", "irq count", irq_cnt, 2);

    // R9 stop
    ctl_begin(8'h18); push_stop(); ctl_end();
    check(st_master == 1'b0, "R9", "master cleared", st_master, 0);
    wait_drained();
    check(st_busy == 1'b0, "R9", "bus free", st_busy, 0);

    // R1 incomplete start request is ignored
    ctl_begin(8'hE8); ctl_end();
    repeat (10) @(negedge clk);
    check(!st_busy && !st_master, "R1", "no start", {st_busy, st_master}, 0);

    // R6 read address acked, R11 receive, R3 short word
    clk_div = 8'd1; half = 2;
    dat_wr(8'hA3);
    ctl_begin(8'hF8); push_start(); push_tx(8'hA3, 8, 1, 1); ctl_end();
    wait_drained();
    check(st_tx == 1'b0, "R6", "mode flipped to receive", st_tx, 0);
    ctl_begin(8'hF8); push_rx(8'h96, 8, 1); ctl_end();
    wait_drained();
    check(rx_data == 8'h96, "R11", "received byte", rx_data, 8'h96);
    check(st_tx == 1'b0, "R12", "written tx ignored", st_tx, 0);
    ctl_begin(8'hF3); push_rx(8'h05, 3, 0); ctl_end();
    wait_drained();
    check(rx_data == 8'hB5, "R3", "3-bit word", rx_data, 8'hB5);
    check(irq_cnt == 5, "R3", "irq per short word", irq_cnt, 5);
    ctl_begin(8'h18); push_stop(); ctl_end();
    wait_drained();

    // R6 read address NACKed: mode unchanged
    dat_wr(8'hA3);
    ctl_begin(8'hF8); push_start(); push_tx(8'hA3, 8, 1, 0); ctl_end();
    wait_drained();
    check(st_tx == 1'b1, "R6", "mode kept on nack", st_tx, 1);
    check(st_lrb == 1'b1, "R8", "nack level", st_lrb, 1);
    ctl_begin(8'h18); push_stop(); ctl_end();
    wait_drained();
    check(st_busy == 1'b0, "R9", "bus free", st_busy, 0);

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule